// File: doc/BRIEF.md
# Prefetch Instruction Queue with Branch Folding

This block sits between the instruction cache and the decode/dispatch stage. It keeps a small circular queue of fetched instruction words, each stored with its byte address. Dispatch always takes the oldest word. Whenever the queue has room for a whole group, a group of `FILL_N` words can arrive from the cache in one clock, and these are appended at the young end. Fetching goes on while dispatch is stalled, and dispatch goes on through a cache miss for as long as the queue holds words.

Every cycle, a scanner looks at all valid entries and picks out the oldest unconditional jump. It works out the jump target while the head word is being dispatched. When it finds a jump, the block does the following on one edge:
- it removes the jump and every younger word;
- it loads the fetch address with the target;
- it keeps all older words queued.

The jump never reaches dispatch. Its cost is hidden whenever older words are still waiting. A taken-branch signal from the execute stage empties the whole queue and moves fetching to the supplied address.

Top module: `prefetch_queue`

## Requirements
- R1: While reset is held and on the first cycle after it, the queue is empty: `disp_valid` is 0, `fetch_req` is 1 and `fetch_pc` equals `RESET_PC` (default 0).
- R2: Words are dispatched oldest first. `disp_pc` and `disp_word` show the head entry, and a word leaves when `disp_valid` and `disp_ready` are both 1.
- R3: `fetch_req` is 1 only when the number of free slots at the start of the cycle is at least `FILL_N`. The queue therefore never holds more than `DEPTH` words.
- R4: A fill is taken on an edge where `fetch_req` and `fill_valid` are both 1. Word j (bits 32j+31..32j of `fill_data`) is appended with address `fetch_pc`+4j, and `fetch_pc` advances by 4·`FILL_N` on that edge.
- R5: With `disp_ready` held at 0, fills continue to be taken until the queue cannot accept another full group.
- R6: A word whose bits 31..26 equal 000010 is an unconditional jump. Its target is its own address plus the sign-extended bits 25..0 shifted left by two. Such a word is never dispatched. When it is the oldest jump in the queue, it and all younger words are dropped, and `fetch_pc` equals the target after the next edge.
- R7: In a cycle where a jump is being folded, `fetch_req` is 0. Any older word at the head is still dispatched in that same cycle.
- R8: While `ex_redirect` is 1, `disp_valid` and `fetch_req` are 0. After that edge the queue is empty and `fetch_pc` equals `ex_target`.
- R9: `disp_valid` is 0 whenever the queue is empty, or when the head word is a jump.
- R10: On a miss (`fill_valid` 0), `fetch_pc` holds its value and queued words keep dispatching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_req | output | 1 | Request for one fill group at `fetch_pc` |
| fetch_pc | output | 32 | Byte address of the group being requested |
| fill_valid | input | 1 | Cache has the requested group this cycle |
| fill_data | input | 32·FILL_N | Group of words, word 0 in the low bits |
| disp_valid | output | 1 | Head word is available for dispatch |
| disp_ready | input | 1 | Dispatch stage takes the head word |
| disp_word | output | 32 | Head instruction word |
| disp_pc | output | 32 | Address of the head word |
| ex_redirect | input | 1 | Taken branch from execute; flush and refetch |
| ex_target | input | 32 | Address to refetch from on `ex_redirect` |

## Verification
Some results depend only on the inputs of the current cycle: dispatch outputs, the fill request and the blanking during a redirect. The bench reads these 1 time unit after it drives the inputs at the falling edge. Results that are registered become visible one rising edge later: the appended fill words, the advanced or redirected `fetch_pc`, and the emptied queue. A folded jump takes two edges in total. The edge that writes the jump makes the fold visible in the next cycle, and the following edge loads the target into `fetch_pc`. The bench samples each of these results in the falling-edge half of the cycle in which it is due. It compares the order of dispatched addresses with a reference walk of the program, in which jumps are followed and never issued. With no jumps present, it also keeps its own occupancy count, from which it predicts `fetch_req`, `disp_valid` and `fetch_pc` cycle by cycle.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  typedef logic [31:0] word_t;
  typedef logic [31:0] addr_t;

  // opcode in bits 31..26 that marks an unconditional jump
  localparam logic [5:0] JUMP_OP = 6'b000010;

  function automatic logic is_ubranch(input word_t w);
    return w[31:26] == JUMP_OP;
  endfunction

  // word offset in bits 25..0, signed, relative to the jump's own address
  function automatic addr_t jump_target(input addr_t pc, input word_t w);
    return pc + {{4{w[25]}}, w[25:0], 2'b00};
  endfunction

  function automatic addr_t seq_pc(input addr_t pc, input int unsigned words);
    return pc + addr_t'(words * 4);
  endfunction

endpackage

// File: rtl/pfq_store.sv
module pfq_store
  import pfq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int FILL_N = 2,
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   wr_en,
  input  logic [PW-1:0]          wr_slot,
  input  word_t [FILL_N-1:0]     wr_word,
  input  addr_t                  wr_pc,
  input  logic [PW-1:0]          rd_head,
  output word_t [DEPTH-1:0]      age_word,
  output addr_t [DEPTH-1:0]      age_pc
);

  word_t mem_w [DEPTH];
  addr_t mem_p [DEPTH];

  // a group lands in consecutive slots starting at the young end
  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int j = 0; j < FILL_N; j++) begin
        mem_w[wr_slot + PW'(j)] <= wr_word[j];
        mem_p[wr_slot + PW'(j)] <= seq_pc(wr_pc, unsigned'(j));
      end
    end
  end

  // view ordered by age: index 0 is the head
  for (genvar g = 0; g < DEPTH; g++) begin : g_age
    assign age_word[g] = mem_w[rd_head + PW'(g)];
    assign age_pc[g]   = mem_p[rd_head + PW'(g)];
  end

endmodule

// File: rtl/pfq_branch_scan.sv
module pfq_branch_scan
  import pfq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  word_t [DEPTH-1:0] age_word,
  input  addr_t [DEPTH-1:0] age_pc,
  input  logic [CW-1:0]     occ,
  output logic              hit,
  output logic [CW-1:0]     hit_pos,
  output addr_t             hit_target
);

  // descending walk so the oldest valid jump wins
  always_comb begin
    hit        = 1'b0;
    hit_pos    = '0;
    hit_target = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if ((CW'(i) < occ) && is_ubranch(age_word[i])) begin
        hit        = 1'b1;
        hit_pos    = CW'(i);
        hit_target = jump_target(age_pc[i], age_word[i]);
      end
    end
  end

endmodule

// File: rtl/pfq_ctrl.sv
module pfq_ctrl
  import pfq_pkg::*;
#(
  parameter int    DEPTH    = 8,
  parameter int    FILL_N   = 2,
  parameter addr_t RESET_PC = '0,
  localparam int   PW       = $clog2(DEPTH),
  localparam int   CW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ex_redirect,
  input  addr_t         ex_target,
  input  logic          fill_valid,
  input  logic          disp_ready,
  input  logic          fold_hit,
  input  logic [CW-1:0] fold_pos,
  input  addr_t         fold_target,
  output logic [PW-1:0] head,
  output logic [PW-1:0] tail,
  output logic [CW-1:0] occ,
  output addr_t         fetch_pc,
  output logic          fetch_req,
  output logic          fill_take,
  output logic          pop,
  output logic          disp_valid,
  output logic          fold_fire
);

  logic [CW-1:0] free_slots;
  logic [CW-1:0] occ_nxt;
  logic [PW-1:0] head_nxt;
  addr_t         pc_nxt;

  assign free_slots = CW'(DEPTH) - occ;
  assign tail       = head + PW'(occ);
  assign fold_fire  = fold_hit && !ex_redirect;
  assign fetch_req  = !ex_redirect && !fold_hit && (free_slots >= CW'(FILL_N));
  assign fill_take  = fetch_req && fill_valid;
  assign disp_valid = !ex_redirect && (occ != '0) && !(fold_hit && (fold_pos == '0));
  assign pop        = disp_valid && disp_ready;

  always_comb begin
    head_nxt = head + PW'(pop);
    if (ex_redirect) begin
      occ_nxt = '0;
      pc_nxt  = ex_target;
    end else if (fold_fire) begin
      occ_nxt = fold_pos - CW'(pop);
      pc_nxt  = fold_target;
    end else begin
      occ_nxt = occ - CW'(pop) + (fill_take ? CW'(FILL_N) : CW'(0));
      pc_nxt  = fill_take ? seq_pc(fetch_pc, FILL_N) : fetch_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head     <= '0;
      occ      <= '0;
      fetch_pc <= RESET_PC;
    end else begin
      head     <= head_nxt;
      occ      <= occ_nxt;
      fetch_pc <= pc_nxt;
    end
  end

endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
  import pfq_pkg::*;
#(
  parameter int          DEPTH    = 8,
  parameter int          FILL_N   = 2,
  parameter logic [31:0] RESET_PC = 32'h0,
  localparam int         PW       = $clog2(DEPTH),
  localparam int         CW       = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  output logic                  fetch_req,
  output logic [31:0]           fetch_pc,
  input  logic                  fill_valid,
  input  logic [FILL_N*32-1:0]  fill_data,
  output logic                  disp_valid,
  input  logic                  disp_ready,
  output logic [31:0]           disp_word,
  output logic [31:0]           disp_pc,
  input  logic                  ex_redirect,
  input  logic [31:0]           ex_target
);

  word_t [FILL_N-1:0] fill_words;
  word_t [DEPTH-1:0]  age_word;
  addr_t [DEPTH-1:0]  age_pc;
  logic [PW-1:0]      head;
  logic [PW-1:0]      tail;
  logic [CW-1:0]      occ;
  logic               fill_take;
  logic               pop;
  logic               fold_hit;
  logic               fold_fire;
  logic [CW-1:0]      fold_pos;
  addr_t              fold_target;

  for (genvar j = 0; j < FILL_N; j++) begin : g_unpack
    assign fill_words[j] = fill_data[32*j +: 32];
  end

  pfq_store #(.DEPTH(DEPTH), .FILL_N(FILL_N)) u_store (
    .clk      (clk),
    .wr_en    (fill_take),
    .wr_slot  (tail),
    .wr_word  (fill_words),
    .wr_pc    (fetch_pc),
    .rd_head  (head),
    .age_word (age_word),
    .age_pc   (age_pc)
  );

  pfq_branch_scan #(.DEPTH(DEPTH)) u_scan (
    .age_word   (age_word),
    .age_pc     (age_pc),
    .occ        (occ),
    .hit        (fold_hit),
    .hit_pos    (fold_pos),
    .hit_target (fold_target)
  );

  pfq_ctrl #(.DEPTH(DEPTH), .FILL_N(FILL_N), .RESET_PC(RESET_PC)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .ex_redirect (ex_redirect),
    .ex_target   (ex_target),
    .fill_valid  (fill_valid),
    .disp_ready  (disp_ready),
    .fold_hit    (fold_hit),
    .fold_pos    (fold_pos),
    .fold_target (fold_target),
    .head        (head),
    .tail        (tail),
    .occ         (occ),
    .fetch_pc    (fetch_pc),
    .fetch_req   (fetch_req),
    .fill_take   (fill_take),
    .pop         (pop),
    .disp_valid  (disp_valid),
    .fold_fire   (fold_fire)
  );

  assign disp_word = age_word[0];
  assign disp_pc   = age_pc[0];

endmodule

// File: rtl/pfq_checker.sv
module pfq_checker
  import pfq_pkg::*;
#(
  parameter int  DEPTH  = 8,
  parameter int  FILL_N = 2,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fetch_req,
  input logic [31:0]   fetch_pc,
  input logic          fill_valid,
  input logic          disp_valid,
  input logic [31:0]   disp_word,
  input logic          ex_redirect,
  input logic [31:0]   ex_target,
  input logic [CW-1:0] occ,
  input logic          fold_fire,
  input logic [31:0]   fold_target
);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

  p_fill_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> ((CW'(DEPTH) - occ) >= CW'(FILL_N)));

  p_fill_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && fill_valid) |=> (fetch_pc == $past(fetch_pc) + 32'(4 * FILL_N)));

  p_fold_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fold_fire |=> (fetch_pc == $past(fold_target)));

  p_no_jump_issue_r6: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> !is_ubranch(disp_word));

  p_fold_no_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fold_fire |-> !fetch_req);

  p_redirect_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ex_redirect |-> (!disp_valid && !fetch_req));

  p_redirect_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ex_redirect |=> ((occ == '0) && (fetch_pc == $past(ex_target))));

  p_empty_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> !disp_valid);

  p_miss_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!fill_valid && !ex_redirect && !fold_fire) |=> $stable(fetch_pc));

endmodule

bind prefetch_queue pfq_checker #(.DEPTH(DEPTH), .FILL_N(FILL_N)) u_pfq_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fetch_req   (fetch_req),
  .fetch_pc    (fetch_pc),
  .fill_valid  (fill_valid),
  .disp_valid  (disp_valid),
  .disp_word   (disp_word),
  .ex_redirect (ex_redirect),
  .ex_target   (ex_target),
  .occ         (occ),
  .fold_fire   (fold_fire),
  .fold_target (fold_target)
);

// File: tb/prefetch_queue_test.sv
module prefetch_queue_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int FILL_N     = 2;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 fetch_req;
  logic [31:0]          fetch_pc;
  logic                 fill_valid = 1'b0;
  logic [FILL_N*32-1:0] fill_data = '0;
  logic                 disp_valid;
  logic                 disp_ready = 1'b0;
  logic [31:0]          disp_word;
  logic [31:0]          disp_pc;
  logic                 ex_redirect = 1'b0;
  logic [31:0]          ex_target = '0;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int mode   = 0;         // 0 no jumps, 1 single jump at 4, 2 scattered jumps
  logic [31:0] exp_pc;    // address of next word expected at dispatch
  int          mcount;    // occupancy model, mode 0 only
  logic [31:0] mpc;       // fetch address model, mode 0 only

  prefetch_queue #(.DEPTH(DEPTH), .FILL_N(FILL_N), .RESET_PC(32'h0)) uut (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_pc(fetch_pc),
    .fill_valid(fill_valid), .fill_data(fill_data), .disp_valid(disp_valid),
    .disp_ready(disp_ready), .disp_word(disp_word), .disp_pc(disp_pc),
    .ex_redirect(ex_redirect), .ex_target(ex_target)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [31:0] prog_word(input int m, input logic [31:0] a);
    int w;
    w = int'(a[31:2]);
    if (m == 1 && a == 32'h4) return {6'b000010, 26'd63};             // to 0x100
    if (m == 2 && (w % 7) == 5) return a[4] ? {6'b000010, 26'd9}      // +9 words
                                            : {6'b000010, 26'h3FFFFFA}; // -6 words
    return {6'b100000, a[27:2]};
  endfunction

  function automatic bit is_jump(input logic [31:0] w);
    return w[31:26] == 6'b000010;
  endfunction

  function automatic logic [31:0] follow(input logic [31:0] a);
    logic [31:0] p = a;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] w = prog_word(mode, p);
      if (is_jump(w)) p = p + 32'($signed(w[25:0])) * 4;
    end
    return p;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input int m);
    rst_n = 1'b0; disp_ready = 0; fill_valid = 0; ex_redirect = 0;
    mode = m; exp_pc = follow(32'h0); mcount = 0; mpc = 32'h0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(disp_valid == 1'b0, "R1 disp_valid", 32'(disp_valid), 32'h0);
    check(fetch_req == 1'b1, "R1 fetch_req", 32'(fetch_req), 32'h1);
    check(fetch_pc == 32'h0, "R1 fetch_pc", fetch_pc, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one clock: drive at the falling edge, check 1 unit later, advance
  task automatic step(input bit rdy, input bit fv, input bit rd, input logic [31:0] tgt);
    disp_ready = rdy; fill_valid = fv; ex_redirect = rd; ex_target = tgt;
    for (int j = 0; j < FILL_N; j++) fill_data[32*j +: 32] = prog_word(mode, fetch_pc + 32'(4*j));
    #1;
    if (rd) begin
      check(!disp_valid && !fetch_req, "R8 quiet", {fetch_req, disp_valid}, 32'h0);
      exp_pc = follow(tgt); mcount = 0; mpc = tgt;
    end else begin
      if (disp_valid && rdy) begin
        check(disp_pc == exp_pc, "R2 order", disp_pc, exp_pc);
        check(disp_word == prog_word(mode, exp_pc), "R6 word", disp_word, prog_word(mode, exp_pc));
        exp_pc = follow(exp_pc + 32'h4);
      end
      if (mode == 0) begin
        check(fetch_req == ((DEPTH - mcount) >= FILL_N), "R3 fetch_req", 32'(fetch_req), 32'(mcount));
        check(disp_valid == (mcount != 0), "R9 disp_valid", 32'(disp_valid), 32'(mcount));
        check(fetch_pc == mpc, "R4 fetch_pc", fetch_pc, mpc);
        if (disp_valid && rdy) mcount--;
        if (fetch_req && fv) begin mcount += FILL_N; mpc += 32'(4*FILL_N); end
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7731));

    // mode 0: fill while dispatch stalled, then drain through a miss
    do_reset(0);
    for (int c = 0; c < 6; c++) step(1'b0, 1'b1, 1'b0, 32'h0);
    check(fetch_req == 1'b0, "R5 full stops fetch", 32'(fetch_req), 32'h0);
    check(fetch_pc == 32'd32, "R5 fetch_pc after fills", fetch_pc, 32'd32);
    check(disp_valid && disp_pc == 32'h0, "R10 dispatch on miss", disp_pc, 32'h0);
    for (int c = 0; c < 9; c++) step(1'b1, 1'b0, 1'b0, 32'h0);
    check(fetch_pc == 32'd32, "R10 pc held on miss", fetch_pc, 32'd32);
    check(disp_valid == 1'b0, "R9 drained", 32'(disp_valid), 32'h0);

    // R8 directed redirect with words queued
    for (int c = 0; c < 3; c++) step(1'b0, 1'b1, 1'b0, 32'h0);
    step(1'b0, 1'b1, 1'b1, 32'h400);
    check(fetch_pc == 32'h400, "R8 target loaded", fetch_pc, 32'h400);
    check(disp_valid == 1'b0, "R8 queue empty", 32'(disp_valid), 32'h0);

    // mode 0 random
    for (int c = 0; c < 600; c++)
      step(1'($urandom % 3 != 0), 1'($urandom % 4 != 0), 1'($urandom % 50 == 0),
           {20'h0, 10'($urandom), 2'b00});

    // mode 1: fold with one older word, dispatched in the fold cycle
    do_reset(1);
    step(1'b1, 1'b1, 1'b0, 32'h0);
    check(fetch_req == 1'b0, "R7 no fetch while folding", 32'(fetch_req), 32'h0);
    check(disp_valid && disp_pc == 32'h0, "R7 older word dispatches", disp_pc, 32'h0);
    step(1'b1, 1'b1, 1'b0, 32'h0);
    check(fetch_pc == 32'h100, "R6 target loaded", fetch_pc, 32'h100);
    for (int c = 0; c < 6; c++) step(1'b1, 1'b1, 1'b0, 32'h0);

    // mode 1 with dispatch stalled: younger word at 8 must never appear
    do_reset(1);
    for (int c = 0; c < 3; c++) step(1'b0, 1'b1, 1'b0, 32'h0);
    for (int c = 0; c < 6; c++) step(1'b1, 1'b0, 1'b0, 32'h0);
    check(exp_pc == 32'h108, "R6 younger dropped", exp_pc, 32'h108);

    // mode 2 random with scattered jumps
    do_reset(2);
    for (int c = 0; c < 3000; c++)
      step(1'($urandom % 4 != 0), 1'($urandom % 3 != 0), 1'($urandom % 80 == 0),
           {20'h0, 10'($urandom), 2'b00});

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule